// File: doc/BRIEF.md
# Two-Input First-Arrival Indicator

This block watches two level inputs that are not timed to the clock. It raises a flag when exactly one of them has gone high after both were low. The flag drops when the other input also goes high. After that it stays low while either input is still high, and the block re-arms only when both inputs are back at zero. So the output depends on the order in which the inputs arrive. Once both inputs have been high together, one of them falling first does not bring the flag back.

Each input passes through a clock-domain synchronizer before the block uses it. The core is a two-state machine, with an armed state and a locked state, and its output comes from a register. It can be used as a "one side acted first" detector, for example for an arbitration hint or a handshake monitor. Reset is active-low and asynchronous.

Top module: `first_arrival_ind`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, z_o is 0 and the machine is in the armed state.
- R2: In the armed state, with both synchronized inputs at 0, z_o stays 0.
- R3: In the armed state, with exactly one synchronized input at 1 (x1 only, or x2 only), z_o becomes 1 and the machine stays armed. A swap straight from one single input to the other keeps z_o at 1.
- R4: In the armed state, with both synchronized inputs at 1, the machine moves to the locked state and z_o becomes 0.
- R5: In the locked state, any input pair other than 00 keeps the machine locked with z_o at 0. This holds even when one input falls while the other stays high.
- R6: In the locked state, the pair 00 returns the machine to the armed state with z_o at 0. A later single-input rise sets z_o to 1 again.
- R7: If both inputs rise in the same sampled cycle from idle, the machine goes straight to the locked state and z_o never pulses high.
- R8: Each input passes through SYNC_STAGES flops (default 2) before the state machine, and z_o is registered. A change on x1_i or x2_i therefore shows on z_o at the third rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| x1_i | input | 1 | First level input, asynchronous |
| x2_i | input | 1 | Second level input, asynchronous |
| z_o | output | 1 | Registered first-arrival flag |

## Verification
An input change reaches z_o at the third rising edge after the change: two synchronizer flops, then the state and output register. The bench drives inputs on the falling edge. It advances a reference model of the synchronizer pipeline and the two-state table after each rising edge, and compares z_o on the next falling edge, so every comparison already includes the three-edge delay. Directed sequences confirm that delay explicitly: z_o must still be low after the second edge and high after the third. Directed sequences also cover simultaneous arrival, one input falling first while locked, and re-arming.

// File: rtl/fai_pkg.sv
package fai_pkg;
  typedef enum logic {
    ST_ARMED  = 1'b0,
    ST_LOCKED = 1'b1
  } fai_state_e;
endpackage

// File: rtl/fai_sync.sv
module fai_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else if (STAGES == 1) chain_q <= d_i[b];
      else chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[LAST];
  end
endmodule

// File: rtl/fai_fsm.sv
module fai_fsm
  import fai_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       a_i,
  input  logic       b_i,
  output fai_state_e state_o,
  output logic       z_o
);
  fai_state_e state_q, state_d;
  logic       z_q, z_d;

  always_comb begin
    state_d = state_q;
    z_d     = 1'b0;
    unique case (state_q)
      ST_ARMED: begin
        if (a_i && b_i) state_d = ST_LOCKED;
        else            z_d     = a_i ^ b_i;
      end
      ST_LOCKED: begin
        if (!a_i && !b_i) state_d = ST_ARMED;
      end
      default: state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARMED;
      z_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      z_q     <= z_d;
    end
  end

  assign state_o = state_q;
  assign z_o     = z_q;
endmodule

// File: rtl/first_arrival_ind.sv
module first_arrival_ind
  import fai_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x1_i,
  input  logic x2_i,
  output logic z_o
);
  localparam int unsigned NUM_IN = 2;

  logic [NUM_IN-1:0] x_sync;
  fai_state_e        state;
  logic              locked;

  fai_sync #(
    .WIDTH (NUM_IN),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({x2_i, x1_i}),
    .q_o   (x_sync)
  );

  fai_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (x_sync[0]),
    .b_i    (x_sync[1]),
    .state_o(state),
    .z_o    (z_o)
  );

  assign locked = (state == ST_LOCKED);
endmodule

// File: rtl/fai_chk.sv
module fai_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] x_sync,
  input logic       locked,
  input logic       z_o
);
  assert_single_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked && (x_sync[0] ^ x_sync[1])) |=> (z_o && !locked));

  assert_both_lock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked && (&x_sync)) |=> (locked && !z_o));

  assert_hold_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && (|x_sync)) |=> (locked && !z_o));

  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_sync == 2'b00) |=> (!locked && !z_o));

  assert_idle_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked && x_sync == 2'b00) |=> !z_o);

  assert_never_high_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |-> !z_o);

  always_comb begin
    if (!rst_ni) assert_reset_R1: assert (!locked && !z_o);
  end
endmodule

bind first_arrival_ind fai_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .x_sync(x_sync),
  .locked(locked),
  .z_o   (z_o)
);

// File: tb/sim_first_arrival_ind.sv
module sim_first_arrival_ind;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x1 = 1'b0, x2 = 1'b0;
  logic z;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  logic [1:0] m_s1 = '0, m_s2 = '0;
  logic       m_lock = 1'b0, m_z = 1'b0;
  string      m_tag = "R1";

  always #2 clk = ~clk;

  first_arrival_ind u0 (
    .clk_i(clk), .rst_ni(rst_n), .x1_i(x1), .x2_i(x2), .z_o(z)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s z_o actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string pick_tag(input logic lk, input logic [1:0] in);
    if (!lk) begin
      if (in == 2'b11) return "R4";
      if (in == 2'b00) return "R2";
      return "R3";
    end
    if (in == 2'b00) return "R6";
    return "R5";
  endfunction

  // model: fsm uses pre-edge sync output, then pipeline shifts
  task automatic model_edge(input logic [1:0] drv);
    m_tag = pick_tag(m_lock, m_s2);
    if (!m_lock) begin
      m_z = (m_s2 == 2'b01) || (m_s2 == 2'b10);
      if (m_s2 == 2'b11) m_lock = 1'b1;
    end else begin
      m_z = 1'b0;
      if (m_s2 == 2'b00) m_lock = 1'b0;
    end
    m_s2 = m_s1;
    m_s1 = drv;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input logic [1:0] v);
    {x2, x1} = v;
    @(posedge clk);
    model_edge(v);
    @(negedge clk);
    check(m_tag, z, m_z);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    @(negedge clk);
    check("R1", z, 1'b0);
    @(negedge clk);
    check("R1", z, 1'b0);
    rst_n = 1'b1;
    step(2'b00);
    check("R1", z, 1'b0);

    // R8: latency of three edges
    for (int i = 0; i < 3; i++) step(2'b00);
    step(2'b01); check("R8", z, 1'b0);
    step(2'b01); check("R8", z, 1'b0);
    step(2'b01); check("R8", z, 1'b1);
    // R3: swap single inputs keeps z high
    for (int i = 0; i < 3; i++) step(2'b10);
    check("R3", z, 1'b1);
    // R4 then R5: one input falls first, stays low
    for (int i = 0; i < 3; i++) step(2'b11);
    check("R4", z, 1'b0);
    for (int i = 0; i < 4; i++) step(2'b01);
    check("R5", z, 1'b0);
    // R6: release and re-arm
    for (int i = 0; i < 3; i++) step(2'b00);
    check("R6", z, 1'b0);
    for (int i = 0; i < 3; i++) step(2'b10);
    check("R6", z, 1'b1);
    // R7: simultaneous rise from idle never pulses
    for (int i = 0; i < 3; i++) step(2'b00);
    for (int i = 0; i < 5; i++) begin
      step(2'b11);
      check("R7", z, 1'b0);
    end
    for (int i = 0; i < 3; i++) step(2'b00);

    // random phase
    for (int n = 0; n < 800; n++) begin
      automatic logic [1:0] v = 2'($urandom());
      automatic int hold = 1 + int'($urandom() % 4);
      for (int h = 0; h < hold; h++) step(v);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule